// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This block runs one complete transfer over a single display auxiliary channel, either to the native register space or as I2C carried over the channel. It accepts one command, hands channel requests to a framer below it, and reads back a classified channel outcome together with the decoded reply code. Five retry counters are kept: channel timeouts, invalid replies, native defers, I2C defers, and a shared counter for short read acknowledgements or write status polls. From these it decides on each outcome whether to reissue the request, wait and reissue, switch a write to status polling, continue a read with fewer bytes, succeed or fail.

When an I2C-space transfer is the last of its group, or when it fails, the block follows it with a zero-length closing request of the same direction that has the middle-of-transaction (MOT) bit cleared. The closing result does not change the reported status. Completion is a one-cycle `done` pulse; `status` holds its code until the next completion.

The command, request and response ports are valid/ready. A command is taken only while the block is idle. A request stays valid with all fields stable until the framer raises `req_ready`; only one request is ever outstanding, and `rsp_ready` is high only while the block waits for the outcome of that request. Wait intervals are counted in clock cycles derived from the `CLK_MHZ` parameter.

Top module: `aux_txn_sequencer`

## Requirements
- R1: `cmd_ready` is high only when idle. Data-phase requests carry MOT=1. Request codes: native write 4'h8, native read 4'h9; I2C codes are {1'b0, MOT, op} with op 2'b00 write, 2'b01 read, 2'b10 status request. For I2C commands `req_addr` is `cmd_addr` shifted right by one; native addresses pass unchanged. `req_offset` starts at 0.
- R2: A request that is not accepted stays valid with stable fields; `rsp_ready` is never high while `req_valid` is.
- R3: Channel outcome 2'd1 (timeout) reissues the request with no wait; the third consecutive timeout fails with status 3'd2 (timeout).
- R4: Channel outcome 2'd2 (invalid reply) first waits INV_WAIT_US microseconds then reissues; a second consecutive one fails with status 3'd3 (protocol error).
- R5: A read receiving reply 4'h2 (native defer) reissues at once; the seventh fails with status 3'd2. Reply 4'h8 (I2C defer) clears the native defer count and counts separately against the same limit.
- R6: On writes the defer limit is the larger of `cfg_wr_defer_max` and 6.
- R7: A read acknowledgement (channel 2'd0, reply 4'h0) returning more bytes than remain fails with 3'd3; fewer bytes reissue with offset advanced and length reduced by the count; a second short acknowledgement fails with 3'd3; an exact count succeeds with 3'd0.
- R8: A write acknowledgement with a nonzero byte count waits POLL_WAIT_US microseconds and issues an I2C status request with MOT as before and length 0; the seventh such acknowledgement fails with 3'd2.
- R9: A write receiving reply 4'h8 issues a length-0 status request with no wait.
- R10: Replies 4'h1 or 4'h4 fail with 3'd1 (NACK); channel outcome 2'd3 fails with 3'd4 (disconnect); any other reply code fails with 3'd5 (unknown).
- R11: An I2C command with `cmd_last` set, or one that fails, is followed by a zero-length request of the same direction with MOT=0; native commands send none; the reported status is that of the data phase.
- R12: All retry counters and the offset restart from zero with every accepted command.
- R13: After reset `status` is 0 and `done` low; `done` pulses for one cycle at completion and `status` holds its code afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_defer_max | input | CNT_W | Configured write defer limit (floor 6) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Idle, command accepted |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_i2c | input | 1 | 1 I2C space, 0 native space |
| cmd_last | input | 1 | Last transfer of its group |
| cmd_addr | input | ADDR_W | Target address |
| cmd_len | input | LEN_W | Byte count |
| req_valid | output | 1 | Request to framer valid |
| req_ready | input | 1 | Framer accepts request |
| req_action | output | 4 | Request code |
| req_addr | output | ADDR_W | Request address |
| req_len | output | LEN_W | Request byte count |
| req_offset | output | LEN_W | Buffer offset for this request |
| rsp_valid | input | 1 | Channel outcome valid |
| rsp_ready | output | 1 | Waiting for outcome |
| rsp_chan | input | 2 | 0 ok, 1 timeout, 2 invalid, 3 disconnect |
| rsp_reply | input | 4 | Decoded reply code |
| rsp_bytes | input | LEN_W | Data bytes returned |
| done | output | 1 | Completion pulse |
| status | output | 3 | Final status code |

## Verification
An outcome that leads straight to another request makes `req_valid` rise on the clock edge after the outcome is accepted, so a scripted framer measures zero cycles between dropping `rsp_valid` and seeing the next request; a wait of N cycles shows up as a gap of N, and each check allows a margin of three cycles above the expected gap and none below it. `done` and the new `status` appear one edge after the last outcome is accepted, and the bench samples them on the falling edge. Every request is popped from a queue of expected requests and compared field by field, and `status` is checked again a few cycles later to confirm that it holds.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  typedef enum logic [1:0] {
    CH_OK      = 2'd0,
    CH_TIMEOUT = 2'd1,
    CH_INVALID = 2'd2,
    CH_HPD     = 2'd3
  } chan_e;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_NACK    = 3'd1,
    ST_TIMEOUT = 3'd2,
    ST_PROTO   = 3'd3,
    ST_HPD     = 3'd4,
    ST_UNKNOWN = 3'd5
  } stat_e;

  typedef enum logic [2:0] {
    V_RETRY,
    V_WAIT_INV,
    V_WAIT_POLL,
    V_PARTIAL,
    V_DONE,
    V_FAIL
  } verdict_e;

  localparam logic [3:0] RP_ACK       = 4'h0;
  localparam logic [3:0] RP_NACK      = 4'h1;
  localparam logic [3:0] RP_DEFER     = 4'h2;
  localparam logic [3:0] RP_I2C_NACK  = 4'h4;
  localparam logic [3:0] RP_I2C_DEFER = 4'h8;

  localparam int C_TO   = 0;
  localparam int C_INV  = 1;
  localparam int C_DFA  = 2;
  localparam int C_DFI  = 3;
  localparam int C_ACK  = 4;
  localparam int NCTR   = 5;
endpackage

// File: rtl/aux_retry_ctr.sv
module aux_retry_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != '1)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == {{(W-1){1'b0}}, 1'b1});

  // R4: a running wait moves down by exactly one per cycle
  a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/aux_reply_eval.sv
module aux_reply_eval
  import aux_seq_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int LEN_W       = 5,
  parameter int INV_LIMIT   = 1,
  parameter int TO_LIMIT    = 2,
  parameter int DEFER_LIMIT = 6
) (
  input  logic                          is_write,
  input  logic [1:0]                    chan,
  input  logic [3:0]                    reply,
  input  logic [LEN_W-1:0]              bytes,
  input  logic [LEN_W-1:0]              remain,
  input  logic [NCTR-1:0][CNT_W-1:0]    cnts,
  input  logic [CNT_W-1:0]              wr_defer_max,
  output verdict_e                      verdict,
  output stat_e                         fail_code,
  output logic [NCTR-1:0]               inc,
  output logic [NCTR-1:0]               clr,
  output logic                          go_status
);
  localparam logic [CNT_W-1:0] LIM_INV = CNT_W'(INV_LIMIT);
  localparam logic [CNT_W-1:0] LIM_TO  = CNT_W'(TO_LIMIT);
  localparam logic [CNT_W-1:0] LIM_DEF = CNT_W'(DEFER_LIMIT);

  logic [CNT_W-1:0] dlim;
  assign dlim = is_write ? wr_defer_max : LIM_DEF;

  always_comb begin
    verdict   = V_RETRY;
    fail_code = ST_OK;
    inc       = '0;
    clr       = '0;
    go_status = 1'b0;
    case (chan_e'(chan))
      CH_OK: begin
        if (!is_write && bytes > remain) begin
          verdict   = V_FAIL;
          fail_code = ST_PROTO;
        end else begin
          clr[C_TO]  = 1'b1;
          clr[C_INV] = 1'b1;
          case (reply)
            RP_ACK: begin
              if (is_write) begin
                if (bytes != '0) begin
                  inc[C_ACK] = 1'b1;
                  go_status  = 1'b1;
                  if (cnts[C_ACK] >= LIM_DEF) begin
                    verdict   = V_FAIL;
                    fail_code = ST_TIMEOUT;
                  end else begin
                    verdict = V_WAIT_POLL;
                  end
                end else begin
                  verdict = V_DONE;
                end
              end else begin
                clr[C_DFA] = 1'b1;
                if (bytes == remain) begin
                  verdict = V_DONE;
                end else begin
                  inc[C_ACK] = 1'b1;
                  if (cnts[C_ACK] >= LIM_INV) begin
                    verdict   = V_FAIL;
                    fail_code = ST_PROTO;
                  end else begin
                    verdict = V_PARTIAL;
                  end
                end
              end
            end
            RP_NACK, RP_I2C_NACK: begin
              verdict   = V_FAIL;
              fail_code = ST_NACK;
            end
            RP_DEFER: begin
              inc[C_DFA] = 1'b1;
              if (cnts[C_DFA] >= dlim) begin
                verdict   = V_FAIL;
                fail_code = ST_TIMEOUT;
              end
            end
            RP_I2C_DEFER: begin
              clr[C_DFA] = 1'b1;
              inc[C_DFI] = 1'b1;
              go_status  = is_write;
              if (cnts[C_DFI] >= dlim) begin
                verdict   = V_FAIL;
                fail_code = ST_TIMEOUT;
              end
            end
            default: begin
              verdict   = V_FAIL;
              fail_code = ST_UNKNOWN;
            end
          endcase
        end
      end
      CH_TIMEOUT: begin
        inc[C_TO] = 1'b1;
        if (cnts[C_TO] >= LIM_TO) begin
          verdict   = V_FAIL;
          fail_code = ST_TIMEOUT;
        end
      end
      CH_INVALID: begin
        inc[C_INV] = 1'b1;
        if (cnts[C_INV] >= LIM_INV) begin
          verdict   = V_FAIL;
          fail_code = ST_PROTO;
        end else begin
          verdict = V_WAIT_INV;
        end
      end
      default: begin
        verdict   = V_FAIL;
        fail_code = ST_HPD;
      end
    endcase
  end
endmodule

// File: rtl/aux_txn_sequencer.sv
module aux_txn_sequencer
  import aux_seq_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int LEN_W        = 5,
  parameter int CNT_W        = 4,
  parameter int CLK_MHZ      = 200,
  parameter int INV_LIMIT    = 1,
  parameter int TO_LIMIT     = 2,
  parameter int DEFER_LIMIT  = 6,
  parameter int INV_WAIT_US  = 400,
  parameter int POLL_WAIT_US = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_wr_defer_max,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_i2c,
  input  logic              cmd_last,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [3:0]        req_action,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [LEN_W-1:0]  req_offset,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [1:0]        rsp_chan,
  input  logic [3:0]        rsp_reply,
  input  logic [LEN_W-1:0]  rsp_bytes,
  output logic              done,
  output logic [2:0]        status
);
  localparam int INV_CYC  = INV_WAIT_US * CLK_MHZ;
  localparam int POLL_CYC = POLL_WAIT_US * CLK_MHZ;
  localparam int TMR_MAX  = (INV_CYC > POLL_CYC) ? INV_CYC : POLL_CYC;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam logic [CNT_W-1:0] DEF_FLOOR = CNT_W'(DEFER_LIMIT);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_WAIT} state_e;

  state_e            state;
  logic              is_write, is_i2c, is_last, closing, mot;
  logic [1:0]        op;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  remain, offset;
  stat_e             final_q;
  logic              done_q;
  logic [2:0]        status_q;

  logic              cmd_fire, rsp_fire, fin, start_close, tmr_load, tmr_last;
  logic [TMR_W-1:0]  tmr_val;
  stat_e             fin_code, fail_code;
  verdict_e          verdict;
  logic              go_status;
  logic [NCTR-1:0]   ev_inc, ev_clr, ctr_inc, ctr_clr;
  logic [NCTR-1:0][CNT_W-1:0] cnts;
  logic [CNT_W-1:0]  wr_defer_max;

  assign cmd_ready  = (state == S_IDLE);
  assign req_valid  = (state == S_REQ);
  assign rsp_ready  = (state == S_RSP);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign rsp_fire   = rsp_valid && rsp_ready;
  assign req_addr   = addr_q;
  assign req_len    = remain;
  assign req_offset = offset;
  assign req_action = (is_i2c || op == 2'b10) ? {1'b0, mot, op} : {3'b100, op[0]};
  assign done       = done_q;
  assign status     = status_q;

  assign wr_defer_max = (cfg_wr_defer_max > DEF_FLOOR) ? cfg_wr_defer_max : DEF_FLOOR;

  aux_reply_eval #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .INV_LIMIT(INV_LIMIT),
    .TO_LIMIT(TO_LIMIT), .DEFER_LIMIT(DEFER_LIMIT)
  ) u_eval (
    .is_write(is_write), .chan(rsp_chan), .reply(rsp_reply),
    .bytes(rsp_bytes), .remain(remain), .cnts(cnts),
    .wr_defer_max(wr_defer_max), .verdict(verdict),
    .fail_code(fail_code), .inc(ev_inc), .clr(ev_clr),
    .go_status(go_status)
  );

  always_comb begin
    fin         = rsp_fire && (verdict == V_DONE || verdict == V_FAIL);
    fin_code    = (verdict == V_DONE) ? ST_OK : fail_code;
    start_close = fin && !closing && is_i2c && (is_last || fin_code != ST_OK);
    tmr_load    = rsp_fire && (verdict == V_WAIT_INV || verdict == V_WAIT_POLL);
    tmr_val     = (verdict == V_WAIT_INV) ? TMR_W'(INV_CYC) : TMR_W'(POLL_CYC);
    ctr_inc     = rsp_fire ? ev_inc : '0;
    ctr_clr     = (cmd_fire || start_close) ? '1 : (rsp_fire ? ev_clr : '0);
  end

  for (genvar gi = 0; gi < NCTR; gi++) begin : g_ctr
    aux_retry_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(ctr_clr[gi]),
      .inc(ctr_inc[gi]), .cnt(cnts[gi])
    );
  end

  aux_wait_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .load_val(tmr_val), .last(tmr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      is_write <= 1'b0;
      is_i2c   <= 1'b0;
      is_last  <= 1'b0;
      closing  <= 1'b0;
      mot      <= 1'b0;
      op       <= 2'b00;
      addr_q   <= '0;
      remain   <= '0;
      offset   <= '0;
      final_q  <= ST_OK;
      done_q   <= 1'b0;
      status_q <= 3'd0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          is_write <= cmd_write;
          is_i2c   <= cmd_i2c;
          is_last  <= cmd_last;
          addr_q   <= cmd_i2c ? (cmd_addr >> 1) : cmd_addr;
          remain   <= cmd_len;
          offset   <= '0;
          mot      <= 1'b1;
          op       <= cmd_write ? 2'b00 : 2'b01;
          closing  <= 1'b0;
          state    <= S_REQ;
        end
        S_REQ: if (req_ready) state <= S_RSP;
        S_RSP: if (rsp_valid) begin
          case (verdict)
            V_RETRY: begin
              state <= S_REQ;
              if (go_status) begin
                op     <= 2'b10;
                remain <= '0;
              end
            end
            V_WAIT_INV: state <= S_WAIT;
            V_WAIT_POLL: begin
              state  <= S_WAIT;
              op     <= 2'b10;
              remain <= '0;
            end
            V_PARTIAL: begin
              offset <= offset + rsp_bytes;
              remain <= remain - rsp_bytes;
              state  <= S_REQ;
            end
            default: begin
              if (start_close) begin
                final_q <= fin_code;
                closing <= 1'b1;
                mot     <= 1'b0;
                op      <= {1'b0, ~is_write};
                remain  <= '0;
                offset  <= '0;
                state   <= S_REQ;
              end else begin
                done_q   <= 1'b1;
                status_q <= closing ? final_q : fin_code;
                state    <= S_IDLE;
              end
            end
          endcase
        end
        S_WAIT: if (tmr_last) state <= S_REQ;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: an unaccepted request keeps its fields
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_action) &&
                                   $stable(req_len) && $stable(req_addr)));

  // R2: at most one request in flight
  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rsp_ready);

  // R13: completion is a single-cycle pulse
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a status request never carries data
  a_r8_status_len0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_action[3] == 1'b0 && req_action[1:0] == 2'b10) |-> (req_len == '0));

  // R11: closing request has MOT cleared and no data
  a_r11_close_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && closing) |-> (req_len == '0 && req_action[2] == 1'b0));
endmodule

// File: tb/sim_aux_txn_sequencer.sv
`timescale 1ns/1ps
module sim_aux_txn_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  cfg_wr_defer_max = 4'd0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_i2c = 1'b0, cmd_last = 1'b0;
  logic        cmd_ready;
  logic [19:0] cmd_addr = '0;
  logic [4:0]  cmd_len = '0;
  logic        req_valid, req_ready = 1'b0;
  logic [3:0]  req_action;
  logic [19:0] req_addr;
  logic [4:0]  req_len, req_offset;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [1:0]  rsp_chan = '0;
  logic [3:0]  rsp_reply = '0;
  logic [4:0]  rsp_bytes = '0;
  logic        done;
  logic [2:0]  status;

  aux_txn_sequencer #(.CLK_MHZ(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_defer_max(cfg_wr_defer_max),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_i2c(cmd_i2c), .cmd_last(cmd_last), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_action(req_action),
    .req_addr(req_addr), .req_len(req_len), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_chan(rsp_chan),
    .rsp_reply(rsp_reply), .rsp_bytes(rsp_bytes), .done(done), .status(status)
  );

  typedef struct {
    logic [3:0]  act;
    logic [19:0] addr;
    logic [4:0]  len;
    logic [4:0]  off;
    int          gap;
    int          stall;
    logic [1:0]  ch;
    logic [3:0]  rp;
    logic [4:0]  nb;
    string       tag;
  } item_t;

  item_t q[$];
  int nvec = 0, nerr = 0;
  int cyc = 0, t_rsp = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] act, input logic [19:0] addr,
                      input logic [4:0] len, input logic [4:0] off, input int gap,
                      input logic [1:0] ch, input logic [3:0] rp, input logic [4:0] nb,
                      input string tag, input int stall = 0);
    item_t it;
    it.act = act; it.addr = addr; it.len = len; it.off = off; it.gap = gap;
    it.stall = stall; it.ch = ch; it.rp = rp; it.nb = nb; it.tag = tag;
    q.push_back(it);
  endtask

  // framer/channel model: pops expected requests and answers them
  task automatic serve();
    item_t it;
    int g;
    g = cyc - t_rsp;
    if (q.size() == 0) begin
      check(0, "R11", "unexpected request", req_action, 4'hf);
      it.act = req_action; it.addr = req_addr; it.len = req_len; it.off = req_offset;
      it.gap = -1; it.stall = 0; it.ch = 2'd0; it.rp = 4'h0; it.nb = req_len; it.tag = "R11";
    end else begin
      it = q.pop_front();
      check(req_action == it.act, it.tag, "request code", req_action, it.act);
      check(req_addr == it.addr, it.tag, "request address", req_addr, it.addr);
      check(req_len == it.len, it.tag, "request length", req_len, it.len);
      check(req_offset == it.off, it.tag, "request offset", req_offset, it.off);
      if (it.gap >= 0)
        check(g >= it.gap && g <= it.gap + 3, it.tag, "cycles before request", g, it.gap);
    end
    for (int s = 0; s < it.stall; s++) begin
      @(negedge clk);
      check(req_valid && req_action == it.act && req_len == it.len, "R2",
            "request held under back-pressure", req_valid, 1);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_chan = it.ch; rsp_reply = it.rp; rsp_bytes = it.nb;
    if (!rsp_ready) check(0, "R2", "rsp_ready after accept", rsp_ready, 1);
    @(negedge clk);
    rsp_valid = 1'b0;
    t_rsp = cyc;
  endtask

  initial begin
    @(posedge rst_n);
    @(negedge clk);
    forever begin
      if (req_valid) serve();
      else @(negedge clk);
    end
  end

  task automatic run(input bit wr, input bit i2c, input bit last,
                     input logic [19:0] addr, input logic [4:0] len,
                     input logic [3:0] cfg, input logic [2:0] exp, input string tag);
    int k;
    cfg_wr_defer_max = cfg;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_i2c = i2c; cmd_last = last;
    cmd_addr = addr; cmd_len = len;
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    check(k < 20000, tag, "completion", k, 0);
    check(status == exp, tag, "final status", status, exp);
    check(q.size() == 0, tag, "requests left unissued", q.size(), 0);
    repeat (3) @(negedge clk);
    check(status == exp && !done, "R13", "status held after done", status, exp);
  endtask

  initial begin
    #20000000;
    check(0, "watchdog", "run did not finish", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check(cmd_ready && !req_valid && !rsp_ready, "R1", "idle after reset", cmd_ready, 1);
    check(!done && status == 3'd0, "R13", "reset outputs", status, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 native read, no closing request
    push(4'h9, 20'h12345, 5'd4, 5'd0, -1, 2'd0, 4'h0, 5'd4, "R1", 2);
    run(0, 0, 1, 20'h12345, 5'd4, 4'd0, 3'd0, "R1");
    // R11 I2C read last: data phase then closing read with MOT=0
    push(4'h5, 20'h00050, 5'd2, 5'd0, -1, 2'd0, 4'h0, 5'd2, "R1");
    push(4'h1, 20'h00050, 5'd0, 5'd0, 0, 2'd0, 4'h0, 5'd0, "R11");
    run(0, 1, 1, 20'h000A0, 5'd2, 4'd0, 3'd0, "R11");
    // R7 short then exact, I2C read not last
    push(4'h5, 20'h00050, 5'd3, 5'd0, -1, 2'd0, 4'h0, 5'd1, "R7");
    push(4'h5, 20'h00050, 5'd2, 5'd1, 0, 2'd0, 4'h0, 5'd2, "R7");
    run(0, 1, 0, 20'h000A0, 5'd3, 4'd0, 3'd0, "R7");
    // R7 two short acks
    push(4'h9, 20'h00100, 5'd4, 5'd0, -1, 2'd0, 4'h0, 5'd1, "R7");
    push(4'h9, 20'h00100, 5'd3, 5'd1, 0, 2'd0, 4'h0, 5'd1, "R7");
    run(0, 0, 1, 20'h00100, 5'd4, 4'd0, 3'd3, "R7");
    // R7 too many bytes
    push(4'h9, 20'h00100, 5'd4, 5'd0, -1, 2'd0, 4'h0, 5'd5, "R7");
    run(0, 0, 1, 20'h00100, 5'd4, 4'd0, 3'd3, "R7");
    // R3 two timeouts then success, then three timeouts
    push(4'h9, 20'h00200, 5'd1, 5'd0, -1, 2'd1, 4'h0, 5'd0, "R3");
    push(4'h9, 20'h00200, 5'd1, 5'd0, 0, 2'd1, 4'h0, 5'd0, "R3");
    push(4'h9, 20'h00200, 5'd1, 5'd0, 0, 2'd0, 4'h0, 5'd1, "R3");
    run(0, 0, 1, 20'h00200, 5'd1, 4'd0, 3'd0, "R3");
    push(4'h9, 20'h00200, 5'd1, 5'd0, -1, 2'd1, 4'h0, 5'd0, "R3");
    push(4'h9, 20'h00200, 5'd1, 5'd0, 0, 2'd1, 4'h0, 5'd0, "R3");
    push(4'h9, 20'h00200, 5'd1, 5'd0, 0, 2'd1, 4'h0, 5'd0, "R3");
    run(0, 0, 1, 20'h00200, 5'd1, 4'd0, 3'd2, "R3");
    // R4 invalid, 400-cycle wait, success; then two invalids
    push(4'h9, 20'h00300, 5'd1, 5'd0, -1, 2'd2, 4'h0, 5'd0, "R4");
    push(4'h9, 20'h00300, 5'd1, 5'd0, 400, 2'd0, 4'h0, 5'd1, "R4");
    run(0, 0, 1, 20'h00300, 5'd1, 4'd0, 3'd0, "R4");
    push(4'h9, 20'h00300, 5'd1, 5'd0, -1, 2'd2, 4'h0, 5'd0, "R4");
    push(4'h9, 20'h00300, 5'd1, 5'd0, 400, 2'd2, 4'h0, 5'd0, "R4");
    run(0, 0, 1, 20'h00300, 5'd1, 4'd0, 3'd3, "R4");
    // R12 counters restart: one invalid allowed again
    push(4'h9, 20'h00300, 5'd1, 5'd0, -1, 2'd2, 4'h0, 5'd0, "R12");
    push(4'h9, 20'h00300, 5'd1, 5'd0, 400, 2'd0, 4'h0, 5'd1, "R12");
    run(0, 0, 1, 20'h00300, 5'd1, 4'd0, 3'd0, "R12");
    // R5 seven native defers on a read
    for (int i = 0; i < 7; i++)
      push(4'h9, 20'h00400, 5'd1, 5'd0, (i == 0) ? -1 : 0, 2'd0, 4'h2, 5'd0, "R5");
    run(0, 0, 1, 20'h00400, 5'd1, 4'd0, 3'd2, "R5");
    // R12 defer count restarts
    push(4'h9, 20'h00400, 5'd1, 5'd0, -1, 2'd0, 4'h2, 5'd0, "R12");
    push(4'h9, 20'h00400, 5'd1, 5'd0, 0, 2'd0, 4'h0, 5'd1, "R12");
    run(0, 0, 1, 20'h00400, 5'd1, 4'd0, 3'd0, "R12");
    // R5 I2C defer clears native defer count
    for (int i = 0; i < 6; i++)
      push(4'h5, 20'h00050, 5'd1, 5'd0, (i == 0) ? -1 : 0, 2'd0, 4'h2, 5'd0, "R5");
    push(4'h5, 20'h00050, 5'd1, 5'd0, 0, 2'd0, 4'h8, 5'd0, "R5");
    for (int i = 0; i < 6; i++)
      push(4'h5, 20'h00050, 5'd1, 5'd0, 0, 2'd0, 4'h2, 5'd0, "R5");
    push(4'h5, 20'h00050, 5'd1, 5'd0, 0, 2'd0, 4'h0, 5'd1, "R5");
    run(0, 1, 0, 20'h000A0, 5'd1, 4'd0, 3'd0, "R5");
    // R6 write defer limit from configuration (8) and floor (6)
    for (int i = 0; i < 9; i++)
      push(4'h8, 20'h00500, 5'd2, 5'd0, (i == 0) ? -1 : 0, 2'd0, 4'h2, 5'd0, "R6");
    run(1, 0, 1, 20'h00500, 5'd2, 4'd8, 3'd2, "R6");
    for (int i = 0; i < 7; i++)
      push(4'h8, 20'h00500, 5'd2, 5'd0, (i == 0) ? -1 : 0, 2'd0, 4'h2, 5'd0, "R6");
    run(1, 0, 1, 20'h00500, 5'd2, 4'd2, 3'd2, "R6");
    // R8 write ack with pending bytes, 300-cycle poll, then closing write
    push(4'h4, 20'h00050, 5'd2, 5'd0, -1, 2'd0, 4'h0, 5'd1, "R8", 1);
    push(4'h6, 20'h00050, 5'd0, 5'd0, 300, 2'd0, 4'h0, 5'd0, "R8");
    push(4'h0, 20'h00050, 5'd0, 5'd0, 0, 2'd0, 4'h0, 5'd0, "R11");
    run(1, 1, 1, 20'h000A0, 5'd2, 4'd0, 3'd0, "R8");
    // R8 seventh pending ack fails, closing still sent
    push(4'h4, 20'h00050, 5'd2, 5'd0, -1, 2'd0, 4'h0, 5'd1, "R8");
    for (int i = 0; i < 6; i++)
      push(4'h6, 20'h00050, 5'd0, 5'd0, 300, 2'd0, 4'h0, 5'd1, "R8");
    push(4'h0, 20'h00050, 5'd0, 5'd0, 0, 2'd0, 4'h0, 5'd0, "R11");
    run(1, 1, 0, 20'h000A0, 5'd2, 4'd0, 3'd2, "R8");
    // R9 I2C defer on write switches to status request
    push(4'h4, 20'h00050, 5'd1, 5'd0, -1, 2'd0, 4'h8, 5'd0, "R9");
    push(4'h6, 20'h00050, 5'd0, 5'd0, 0, 2'd0, 4'h0, 5'd0, "R9");
    run(1, 1, 0, 20'h000A0, 5'd1, 4'd0, 3'd0, "R9");
    // R10 NACK on I2C write, failure forces closing
    push(4'h4, 20'h00050, 5'd1, 5'd0, -1, 2'd0, 4'h1, 5'd0, "R10");
    push(4'h0, 20'h00050, 5'd0, 5'd0, 0, 2'd0, 4'h0, 5'd0, "R11");
    run(1, 1, 0, 20'h000A0, 5'd1, 4'd0, 3'd1, "R10");
    // R10 I2C NACK code, disconnect, unknown code
    push(4'h9, 20'h00600, 5'd1, 5'd0, -1, 2'd0, 4'h4, 5'd0, "R10");
    run(0, 0, 1, 20'h00600, 5'd1, 4'd0, 3'd1, "R10");
    push(4'h9, 20'h00600, 5'd1, 5'd0, -1, 2'd3, 4'h0, 5'd0, "R10");
    run(0, 0, 1, 20'h00600, 5'd1, 4'd0, 3'd4, "R10");
    push(4'h9, 20'h00600, 5'd1, 5'd0, -1, 2'd0, 4'h3, 5'd0, "R10");
    run(0, 0, 1, 20'h00600, 5'd1, 4'd0, 3'd5, "R10");

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule